// File: doc/BRIEF.md
# High-Address / General-Purpose I/O Port

This block is an 8-bit port that serves one of two roles, fixed by the operating mode. In single-chip or bootstrap mode, it is a general-purpose I/O port. It has a data latch and a direction register, both reached through a small register bus. Each pin is either an input or an output. In expanded-multiplexed or test mode, all eight pins become outputs. They carry the upper byte (bits 15 to 8) of the external address bus, and the direction register no longer has any effect on them.

The mode input is captured on every clock edge while reset is high. After reset is released, the captured mode is held, so the pin function cannot change until the next reset. The block samples pin levels through a two-stage synchronizer before they reach readback. Register writes are always accepted, in every mode. Bus timing and pad circuitry are outside this block.

Top module: `hap_port_top`

## Requirements
- R1: The data register is at bus offset 0x04 and the direction register at 0x06. A read of any other offset returns 0x00, and a write to any other offset changes nothing.
- R2: After reset in single-chip mode, the direction register and the data latch read 0x00, and every pin output enable is 0.
- R3: In single-chip or bootstrap mode, a direction bit of 1 sets that pin's output enable and drives the matching data latch bit on the pin. A direction bit of 0 clears the output enable.
- R4: In single-chip or bootstrap mode, a data read returns, bit by bit, the data latch for output pins and the synchronized pin level for input pins.
- R5: A change on the pin inputs appears in data readback exactly two clock edges later, not one.
- R6: Mode encoding is 00 single-chip, 01 expanded-multiplexed, 10 bootstrap and 11 test; bit 0 set selects address mode. In address mode, all output enables are 1 and pin n carries address bit n+8, so pin 7 carries A15.
- R7: In address mode, writes to the direction and data registers update the stored values (the direction value reads back) but leave the pins unchanged.
- R8: The mode is sampled while reset is high and held afterwards. A change on the mode input after reset has no effect until the next reset.
- R9: In address mode, a data register read returns the address byte being driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode is sampled while high |
| mode_i | input | 2 | Operating mode select |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| hi_addr_i | input | 8 | External address bits 15..8 |
| pin_in | input | 8 | Sensed pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
The assertions check several properties on every cycle. A write lands in the addressed register one edge later, and the captured mode stays fixed while reset is low. The synchronizer output equals the pin level from two edges earlier. In address mode, the outputs are fully enabled and readback returns the address byte. Only the bench scenarios can show the rest. These are the bit-by-bit mixing of latch and pin levels under varied direction patterns, decoding of unused offsets, and reset clearing the registers after a stint in address mode. They also include the mode input being ignored after reset, in both directions of change.

// File: rtl/hap_pkg.sv
package hap_pkg;
    localparam int PORT_W = 8;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_EXPAND = 2'b01,
        MODE_BOOT   = 2'b10,
        MODE_TEST   = 2'b11
    } port_mode_e;

    typedef struct packed {
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] val;
    } pin_drive_t;

    // Address-bus role is selected by the low mode bit.
    function automatic logic is_addr_mode(port_mode_e m);
        return m[0];
    endfunction
endpackage

// File: rtl/hap_mode_latch.sv
module hap_mode_latch
    import hap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_mode_e mode_i,
    output port_mode_e mode_q
);
    always_ff @(posedge clk) begin
        if (rst) mode_q <= mode_i;
    end

    // R8: captured mode never moves while out of reset
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $stable(mode_q));
endmodule

// File: rtl/hap_regs.sv
module hap_regs
    import hap_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_OFS = 4,
    parameter int DIR_OFS  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] dir_q
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (we) begin
            if (addr == DATA_A) data_q <= wdata;
            if (addr == DIR_A)  dir_q  <= wdata;
        end
    end

    // R7: writes land regardless of mode
    p_dir_write_r7: assert property (@(posedge clk) disable iff (rst)
        (we && addr == DIR_A) |=> dir_q == $past(wdata));
    p_data_write_r7: assert property (@(posedge clk) disable iff (rst)
        (we && addr == DATA_A) |=> data_q == $past(wdata));
    // R1: writes elsewhere leave both registers alone
    p_other_write_r1: assert property (@(posedge clk) disable iff (rst)
        (we && addr != DIR_A && addr != DATA_A) |=> ($stable(dir_q) && $stable(data_q)));
endmodule

// File: rtl/hap_sync.sv
module hap_sync
    import hap_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] d,
    output logic [PORT_W-1:0] q
);
    logic [PORT_W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= '0;
            else     stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];

    if (STAGES == 2) begin : g_chk
        // R5: two-edge latency from pin to readback
        p_sync_latency_r5: assert property (@(posedge clk)
            disable iff (rst || $past(rst) || $past(rst, 2))
            q == $past(d, 2));
    end
endmodule

// File: rtl/hap_mux.sv
module hap_mux
    import hap_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_OFS = 4,
    parameter int DIR_OFS  = 6
) (
    input  port_mode_e        mode,
    input  logic [PORT_W-1:0] data_q,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] hi_addr,
    input  logic [PORT_W-1:0] pins_sync,
    input  logic [ADDR_W-1:0] addr,
    output pin_drive_t        drive,
    output logic [PORT_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);

    logic addr_role;
    logic [PORT_W-1:0] data_view;

    always_comb begin
        addr_role = is_addr_mode(mode);
        if (addr_role) begin
            drive.oe  = '1;
            drive.val = hi_addr;
        end else begin
            drive.oe  = dir_q;
            drive.val = data_q;
        end
        data_view = (drive.oe & drive.val) | (~drive.oe & pins_sync);
        if (addr == DATA_A)     rdata = data_view;
        else if (addr == DIR_A) rdata = dir_q;
        else                    rdata = '0;
    end
endmodule

// File: rtl/hap_port_top.sv
module hap_port_top
    import hap_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_OFS    = 4,
    parameter int DIR_OFS     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        hi_addr_i,
    input  logic [7:0]        pin_in,
    output logic [7:0]        pin_oe,
    output logic [7:0]        pin_out
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

    port_mode_e        mode_q;
    logic [PORT_W-1:0] data_q, dir_q, pins_sync;
    pin_drive_t        drive;

    hap_mode_latch u_mode (
        .clk(clk), .rst(rst), .mode_i(port_mode_e'(mode_i)), .mode_q(mode_q)
    );

    hap_regs #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .data_q(data_q), .dir_q(dir_q)
    );

    hap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync)
    );

    hap_mux #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)) u_mux (
        .mode(mode_q), .data_q(data_q), .dir_q(dir_q), .hi_addr(hi_addr_i),
        .pins_sync(pins_sync), .addr(bus_addr), .drive(drive), .rdata(bus_rdata)
    );

    assign pin_oe  = drive.oe;
    assign pin_out = drive.val;

    // R6: address role drives every pin with the address byte
    p_addr_drive_r6: assert property (@(posedge clk) disable iff (rst)
        mode_q[0] |-> (pin_oe == 8'hFF && pin_out == hi_addr_i));
    // R9: data readback in address role mirrors the address byte
    p_addr_read_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_q[0] && bus_addr == DATA_A) |-> bus_rdata == hi_addr_i);
    // R3: general role enables only the directed pins
    p_gp_oe_r3: assert property (@(posedge clk) disable iff (rst)
        !mode_q[0] |-> pin_oe == dir_q);
endmodule

// File: tb/hap_port_top_bench.sv
module hap_port_top_bench;
    logic       clk = 0;
    logic       rst = 1;
    logic [1:0] mode_i = 2'b00;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_we = 0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] hi_addr_i = 8'h00;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe, pin_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hap_port_top u_hap_port_top (
        .clk(clk), .rst(rst), .mode_i(mode_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hi_addr_i(hi_addr_i), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // {dir, data, pins}
    localparam logic [23:0] VEC [6] = '{
        24'hFF_A5_00, 24'h00_FF_3C, 24'hF0_5A_A5,
        24'h0F_C3_F0, 24'h81_7E_66, 24'h55_00_FF
    };

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(logic [1:0] m);
        @(negedge clk);
        rst = 1; mode_i = m;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    initial begin
        logic [7:0] r;
        do_reset(2'b00);
        @(negedge clk);
        rd(4'h6, r); check("R2", "dir reset", r, 8'h00);
        check("R2", "oe reset", pin_oe, 8'h00);
        wr(4'h6, 8'hFF);
        rd(4'h4, r); check("R2", "data latch reset", r, 8'h00);
        wr(4'h6, 8'h00);

        // Vector walk, general-purpose role
        foreach (VEC[i]) begin
            logic [7:0] dir, dat, pins;
            {dir, dat, pins} = VEC[i];
            wr(4'h6, dir);
            wr(4'h4, dat);
            pin_in = pins;
            repeat (2) @(negedge clk);
            check("R3", "oe", pin_oe, dir);
            check("R3", "driven bits", pin_out & dir, dat & dir);
            rd(4'h4, r); check("R4", "mixed readback", r, (dir & dat) | (~dir & pins));
        end

        // R1: unused offsets
        rd(4'h5, r); check("R1", "offset 5 read", r, 8'h00);
        rd(4'h0, r); check("R1", "offset 0 read", r, 8'h00);
        wr(4'h6, 8'h0F);
        wr(4'h7, 8'hAA);
        rd(4'h6, r); check("R1", "dir after stray write", r, 8'h0F);

        // R5: exactly two edges of latency
        wr(4'h6, 8'h00);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'h96;
        @(negedge clk);
        rd(4'h4, r); check("R5", "after one edge", r, 8'h00);
        @(negedge clk);
        rd(4'h4, r); check("R5", "after two edges", r, 8'h96);

        // Bootstrap behaves as general-purpose
        do_reset(2'b10);
        check("R2", "oe reset bootstrap", pin_oe, 8'h00);
        wr(4'h6, 8'h3C);
        wr(4'h4, 8'h24);
        check("R3", "bootstrap oe", pin_oe, 8'h3C);
        check("R3", "bootstrap out", pin_out & 8'h3C, 8'h24);

        // Expanded: address role
        hi_addr_i = 8'hA5;
        do_reset(2'b01);
        check("R6", "expanded oe", pin_oe, 8'hFF);
        check("R6", "expanded out", pin_out, 8'hA5);
        hi_addr_i = 8'h80;
        #0.5 check("R6", "bit7 carries A15", pin_out, 8'h80);
        rd(4'h4, r); check("R9", "addr readback", r, 8'h80);
        wr(4'h6, 8'h0F);
        wr(4'h4, 8'h33);
        rd(4'h6, r); check("R7", "dir stored", r, 8'h0F);
        check("R7", "oe unchanged", pin_oe, 8'hFF);
        check("R7", "out unchanged", pin_out, 8'h80);
        mode_i = 2'b00;
        repeat (2) @(negedge clk);
        check("R8", "oe held after mode change", pin_oe, 8'hFF);

        // Test mode
        hi_addr_i = 8'h5A;
        do_reset(2'b11);
        check("R6", "test oe", pin_oe, 8'hFF);
        check("R6", "test out", pin_out, 8'h5A);

        // Back to single-chip; mode change afterwards ignored
        do_reset(2'b00);
        check("R2", "oe cleared after addr mode", pin_oe, 8'h00);
        rd(4'h6, r); check("R2", "dir cleared", r, 8'h00);
        mode_i = 2'b01;
        repeat (2) @(negedge clk);
        check("R8", "single-chip held", pin_oe, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule